// File: doc/BRIEF.md
# Multithread Core Control Register Block

This block sits on a 64-bit register bus as a slave and gives a controlling agent command and status access to up to four hardware threads of a single processor core. Every access moves a whole 64-bit word. The block derives the register index from the byte address by shifting it right by three. Four registers are implemented: a thread-state view, a thread-info word, a direct-control command register and a RAS status view. The block numbers bits MSB-first, so bit n of a register is bit 63-n of the bus word. Each thread owns one byte lane of the command word. Thread i's lane occupies word bits 63-8i down to 56-8i.

The block holds a run/stop flag for each thread and samples a halted input from each thread. A write to the direct-control register is applied to each thread in a fixed order: stop, then start, then soft reset, then clear-maintenance. The result is the thread's new run/stop state. Each recognised command also produces a single-cycle pulse toward its thread. A sticky flag records every access the block does not implement: a stray command bit, an unknown index, a misaligned address, or a write or read aimed at a register that does not accept that direction.

The bus side is a two-state machine. In the state IDLE, a request with `req_valid` high is accepted at the clock edge and the machine moves to ACK. In the state ACK, `rsp_ready` and any command pulses are high for that one cycle, and the machine always returns to IDLE at the next edge. A request seen in ACK is not accepted.

Top module: `core_thread_ctl`

## Requirements
- R1: The register index is the byte address shifted right by 3, and an access is legal only when the three low address bits are zero. Index 0x412 selects thread state, 0x413 thread info, 0x449 direct control and 0x454 RAS status.
- R2: A request is accepted only in IDLE. `rsp_ready` is high for exactly the one cycle after the accepting edge (state ACK). A request still asserted in ACK is ignored, so a request held high for two edges yields one response.
- R3: A thread-state read returns word bit 7-i equal to halted input i, sampled at the accepting edge (MSB-first bit 56+i), and every other bit reads 0.
- R4: A RAS status read returns word bits 63-8i and 62-8i both set when thread i is stopped (MSB-first bits 8i and 8i+1), and every other bit reads 0.
- R5: A thread-info read returns zero whatever the thread inputs are.
- R6: In a direct-control write, lane bit 0 of thread i (word bit 56-8i, MSB-first 7+8i) stops the thread. `thr_stopped[i]` is 1 from the ACK cycle on.
- R7: Lane bit 1 (word bit 57-8i, MSB-first 6+8i) starts the thread and clears `thr_stopped[i]`. A stop and a start in the same write leave the thread running.
- R8: Lane bit 4 (word bit 60-8i, MSB-first 3+8i) is clear-maintenance. It resumes the thread exactly as start does and raises its own pulse.
- R9: Lane bit 3 (word bit 59-8i, MSB-first 4+8i) raises a soft-reset pulse for thread i and leaves its run/stop state unchanged.
- R10: Each command pulse is high for exactly one cycle, the ACK cycle of the write that carried it. Threads are independent.
- R11: A direct-control write with any set bit outside the recognised command bits of the existing threads sets `unimpl_flag`. The flag stays set until reset, and the recognised bits of that write still act.
- R12: An unknown index, a misaligned address, a write to a read-only register or a read of the direct-control register sets `unimpl_flag`, returns zero data and changes no thread state.
- R13: During and after reset, `rsp_ready`, every pulse, `thr_stopped` and `unimpl_flag` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 64 | Write data |
| thr_halted | input | NTHR | Halted indication from each thread |
| rsp_ready | output | 1 | Response strobe, one cycle per accepted request |
| rsp_rdata | output | 64 | Read data, valid with rsp_ready |
| thr_stopped | output | NTHR | Run/stop state of each thread (1 = stopped) |
| stop_pls | output | NTHR | Stop command pulse |
| start_pls | output | NTHR | Start command pulse |
| sreset_pls | output | NTHR | Soft-reset pulse |
| clrmnt_pls | output | NTHR | Clear-maintenance pulse |
| unimpl_flag | output | 1 | Sticky unimplemented-access flag |

## Verification
Two things can happen in one cycle: a direct-control write can stop and resume the same thread, and it can also carry command bits for several threads together with stray bits. The bench sends stop with start, and start on one thread with clear-maintenance on another, in a single word. It then judges the outcome from `thr_stopped` and from a later RAS read. A write that mixes a valid stop with an undefined lane bit must both stop the thread and raise the flag, and the bench checks the two effects separately at the ports.

// File: rtl/ctl_pkg.sv
package ctl_pkg;

    localparam int WORD_W = 64;
    localparam int LANE_W = 8;

    // Register indices (byte address >> 3); decoded by the bus side
    localparam int IDX_THR_STATE = 'h412;
    localparam int IDX_THR_INFO  = 'h413;
    localparam int IDX_DIRECT    = 'h449;
    localparam int IDX_RAS       = 'h454;

    // Bit positions inside one thread's command byte lane (LSB of lane = 0)
    localparam int CB_STOP   = 0;
    localparam int CB_START  = 1;
    localparam int CB_SRESET = 3;
    localparam int CB_CLRMNT = 4;

    localparam logic [LANE_W-1:0] LANE_CMD_MASK =
        LANE_W'((1 << CB_STOP) | (1 << CB_START) | (1 << CB_SRESET) | (1 << CB_CLRMNT));

    typedef enum logic [2:0] {
        K_NONE,
        K_STATE,
        K_INFO,
        K_DIRECT,
        K_RAS
    } reg_kind_e;

    typedef enum logic {
        ST_IDLE,
        ST_ACK
    } bus_state_e;

    // Lane of thread t occupies word bits [63-8t -: 8]
    function automatic int lane_lsb(input int t);
        return WORD_W - LANE_W * (t + 1);
    endfunction

    // All recognised command bits for the first n threads
    function automatic logic [WORD_W-1:0] cmd_word_mask(input int n);
        logic [WORD_W-1:0] m;
        m = '0;
        for (int t = 0; t < n; t++) begin
            m = m | (WORD_W'(LANE_CMD_MASK) << lane_lsb(t));
        end
        return m;
    endfunction

endpackage

// File: rtl/ctl_decode.sv
module ctl_decode
    import ctl_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    output reg_kind_e         kind,
    output logic              legal
);

    localparam logic [ADDR_W-1:0] A_STATE  = ADDR_W'(IDX_THR_STATE);
    localparam logic [ADDR_W-1:0] A_INFO   = ADDR_W'(IDX_THR_INFO);
    localparam logic [ADDR_W-1:0] A_DIRECT = ADDR_W'(IDX_DIRECT);
    localparam logic [ADDR_W-1:0] A_RAS    = ADDR_W'(IDX_RAS);

    logic [ADDR_W-1:0] index;
    logic              aligned;

    always_comb begin
        index   = addr >> 3;
        aligned = (addr[2:0] == 3'b000);
        kind    = K_NONE;
        if (aligned) begin
            unique case (index)
                A_STATE:  kind = K_STATE;
                A_INFO:   kind = K_INFO;
                A_DIRECT: kind = K_DIRECT;
                A_RAS:    kind = K_RAS;
                default:  kind = K_NONE;
            endcase
        end
        if (kind == K_NONE) begin
            legal = 1'b0;
        end else if (wr) begin
            legal = (kind == K_DIRECT);
        end else begin
            legal = (kind != K_DIRECT);
        end
    end

endmodule

// File: rtl/ctl_thread_slot.sv
module ctl_thread_slot
    import ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              apply,
    input  logic [LANE_W-1:0] cmd,
    output logic              stopped,
    output logic              p_stop,
    output logic              p_start,
    output logic              p_sreset,
    output logic              p_clrmnt
);

    logic stopped_nxt;

    // Fixed order: stop, start, soft reset (no state effect), clear-maintenance
    always_comb begin
        stopped_nxt = stopped;
        if (apply) begin
            if (cmd[CB_STOP])   stopped_nxt = 1'b1;
            if (cmd[CB_START])  stopped_nxt = 1'b0;
            if (cmd[CB_CLRMNT]) stopped_nxt = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stopped  <= 1'b0;
            p_stop   <= 1'b0;
            p_start  <= 1'b0;
            p_sreset <= 1'b0;
            p_clrmnt <= 1'b0;
        end else begin
            stopped  <= stopped_nxt;
            p_stop   <= apply & cmd[CB_STOP];
            p_start  <= apply & cmd[CB_START];
            p_sreset <= apply & cmd[CB_SRESET];
            p_clrmnt <= apply & cmd[CB_CLRMNT];
        end
    end

endmodule

// File: rtl/ctl_read_mux.sv
module ctl_read_mux
    import ctl_pkg::*;
#(
    parameter int NTHR = 4
) (
    input  reg_kind_e          kind,
    input  logic               legal,
    input  logic [NTHR-1:0]    halted,
    input  logic [NTHR-1:0]    stopped,
    output logic [WORD_W-1:0]  rdata
);

    logic [WORD_W-1:0] state_word;
    logic [WORD_W-1:0] ras_word;

    always_comb begin
        state_word = '0;
        ras_word   = '0;
        for (int t = 0; t < NTHR; t++) begin
            state_word[7 - t]                   = halted[t];
            ras_word[WORD_W - 1 - LANE_W * t]   = stopped[t];
            ras_word[WORD_W - 2 - LANE_W * t]   = stopped[t];
        end
    end

    always_comb begin
        rdata = '0;
        if (legal) begin
            unique case (kind)
                K_STATE:  rdata = state_word;
                K_RAS:    rdata = ras_word;
                K_INFO:   rdata = '0;
                K_DIRECT: rdata = '0;
                K_NONE:   rdata = '0;
                default:  rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/core_thread_ctl.sv
module core_thread_ctl
    import ctl_pkg::*;
#(
    parameter int NTHR   = 4,
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [63:0]       req_wdata,
    input  logic [NTHR-1:0]   thr_halted,
    output logic              rsp_ready,
    output logic [63:0]       rsp_rdata,
    output logic [NTHR-1:0]   thr_stopped,
    output logic [NTHR-1:0]   stop_pls,
    output logic [NTHR-1:0]   start_pls,
    output logic [NTHR-1:0]   sreset_pls,
    output logic [NTHR-1:0]   clrmnt_pls,
    output logic              unimpl_flag
);

    localparam logic [WORD_W-1:0] KNOWN_BITS = cmd_word_mask(NTHR);

    bus_state_e        state_q, state_d;
    reg_kind_e         kind;
    logic              legal;
    logic              accept;
    logic              do_direct;
    logic              stray_bits;
    logic [WORD_W-1:0] rd_value;

    ctl_decode #(.ADDR_W(ADDR_W)) dec_i (
        .addr  (req_addr),
        .wr    (req_write),
        .kind  (kind),
        .legal (legal)
    );

    ctl_read_mux #(.NTHR(NTHR)) rmux_i (
        .kind    (kind),
        .legal   (legal & ~req_write),
        .halted  (thr_halted),
        .stopped (thr_stopped),
        .rdata   (rd_value)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req_valid) state_d = ST_ACK;
            ST_ACK:  state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    assign accept     = (state_q == ST_IDLE) && req_valid;
    assign do_direct  = accept && req_write && legal && (kind == K_DIRECT);
    assign stray_bits = |(req_wdata & ~KNOWN_BITS);
    assign rsp_ready  = (state_q == ST_ACK);

    // Outputs registered on the accepting edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_rdata   <= '0;
            unimpl_flag <= 1'b0;
        end else if (accept) begin
            rsp_rdata <= rd_value;
            if (!legal || (do_direct && stray_bits)) begin
                unimpl_flag <= 1'b1;
            end
        end
    end

    for (genvar t = 0; t < NTHR; t++) begin : g_thr
        ctl_thread_slot slot_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .apply    (do_direct),
            .cmd      (req_wdata[lane_lsb(t) +: LANE_W]),
            .stopped  (thr_stopped[t]),
            .p_stop   (stop_pls[t]),
            .p_start  (start_pls[t]),
            .p_sreset (sreset_pls[t]),
            .p_clrmnt (clrmnt_pls[t])
        );
    end

endmodule

// File: rtl/ctl_checker.sv
module ctl_checker #(
    parameter int NTHR = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            rsp_ready,
    input logic [NTHR-1:0] thr_stopped,
    input logic [NTHR-1:0] stop_pls,
    input logic [NTHR-1:0] start_pls,
    input logic [NTHR-1:0] sreset_pls,
    input logic [NTHR-1:0] clrmnt_pls,
    input logic            unimpl_flag
);

    AST_ACK_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_ready |=> !rsp_ready); // R2

    AST_PULSE_IN_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (|{stop_pls, start_pls, sreset_pls, clrmnt_pls}) |-> rsp_ready); // R10

    AST_LONE_STOP_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
        ((stop_pls & ~start_pls & ~clrmnt_pls & ~thr_stopped) == '0)); // R6

    AST_RESUME_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
        (((start_pls | clrmnt_pls) & thr_stopped) == '0)); // R7

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        unimpl_flag |=> unimpl_flag); // R11

    AST_STATE_ONLY_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (thr_stopped != $past(thr_stopped)) |-> rsp_ready); // R12

endmodule

bind core_thread_ctl ctl_checker #(.NTHR(NTHR)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .rsp_ready   (rsp_ready),
    .thr_stopped (thr_stopped),
    .stop_pls    (stop_pls),
    .start_pls   (start_pls),
    .sreset_pls  (sreset_pls),
    .clrmnt_pls  (clrmnt_pls),
    .unimpl_flag (unimpl_flag)
);

// File: tb/core_thread_ctl_tb_top.sv
module core_thread_ctl_tb_top;

    localparam int NTHR   = 4;
    localparam int ADDR_W = 16;

    localparam logic [ADDR_W-1:0] A_STATE  = 16'h412 << 3;
    localparam logic [ADDR_W-1:0] A_INFO   = 16'h413 << 3;
    localparam logic [ADDR_W-1:0] A_DIRECT = 16'h449 << 3;
    localparam logic [ADDR_W-1:0] A_RAS    = 16'h454 << 3;

    typedef struct packed {
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [63:0]       wdata;
        logic [3:0]        halted;
        logic [63:0]       exp_rdata;
        logic [3:0]        exp_stopped;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{1'b0, A_STATE,  64'h0,                   4'b0000, 64'h0,                   4'b0000}, // R3
        '{1'b0, A_STATE,  64'h0,                   4'b0101, 64'h0000_0000_0000_00A0, 4'b0000}, // R3
        '{1'b0, A_STATE,  64'h0,                   4'b1111, 64'h0000_0000_0000_00F0, 4'b0000}, // R3
        '{1'b0, A_RAS,    64'h0,                   4'b0000, 64'h0,                   4'b0000}, // R4
        '{1'b1, A_DIRECT, 64'h0001_0000_0000_0000, 4'b0000, 64'h0,                   4'b0010}, // R6
        '{1'b0, A_RAS,    64'h0,                   4'b0000, 64'h00C0_0000_0000_0000, 4'b0010}, // R4
        '{1'b1, A_DIRECT, 64'h0100_0001_0000_0000, 4'b0000, 64'h0,                   4'b1011}, // R6
        '{1'b0, A_RAS,    64'h0,                   4'b0000, 64'hC0C0_00C0_0000_0000, 4'b1011}, // R4
        '{1'b1, A_DIRECT, 64'h0002_0010_0000_0000, 4'b0000, 64'h0,                   4'b0001}, // R8
        '{1'b1, A_DIRECT, 64'h0300_0000_0000_0000, 4'b0000, 64'h0,                   4'b0000}, // R7
        '{1'b0, A_INFO,   64'h0,                   4'b1111, 64'h0,                   4'b0000}, // R5
        '{1'b1, A_DIRECT, 64'h0000_0800_0000_0000, 4'b0000, 64'h0,                   4'b0000}, // R9
        '{1'b0, A_RAS,    64'h0,                   4'b1010, 64'h0,                   4'b0000}  // R1
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_write = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [63:0]       req_wdata = '0;
    logic [NTHR-1:0]   thr_halted = '0;
    logic              rsp_ready;
    logic [63:0]       rsp_rdata;
    logic [NTHR-1:0]   thr_stopped, stop_pls, start_pls, sreset_pls, clrmnt_pls;
    logic              unimpl_flag;

    int total = 0;
    int bad   = 0;

    logic              got_ready;
    logic [63:0]       got_rdata;
    logic [NTHR-1:0]   got_stop, got_start, got_sreset, got_clrmnt;

    always #5 clk = ~clk;

    core_thread_ctl #(.NTHR(NTHR), .ADDR_W(ADDR_W)) dut_i (.*);

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic access(input logic wr, input logic [ADDR_W-1:0] a, input logic [63:0] d);
        @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = a;
        req_wdata = d;
        @(negedge clk);
        req_valid  = 1'b0;
        got_ready  = rsp_ready;
        got_rdata  = rsp_rdata;
        got_stop   = stop_pls;
        got_start  = start_pls;
        got_sreset = sreset_pls;
        got_clrmnt = clrmnt_pls;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        // R13: outputs during reset
        chk("R13 ready in reset", 64'(rsp_ready), 64'h0);
        chk("R13 stopped in reset", 64'(thr_stopped), 64'h0);
        chk("R13 pulses in reset", 64'({stop_pls, start_pls, sreset_pls, clrmnt_pls}), 64'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R13 flag after reset", 64'(unimpl_flag), 64'h0);

        // Vector table
        for (int v = 0; v < NV; v++) begin
            thr_halted = VECS[v].halted;
            access(VECS[v].wr, VECS[v].addr, VECS[v].wdata);
            chk($sformatf("R2 ready vec%0d", v), 64'(got_ready), 64'h1);
            if (!VECS[v].wr)
                chk($sformatf("R3/R4/R5 rdata vec%0d", v), got_rdata, VECS[v].exp_rdata);
            chk($sformatf("R6/R7/R8 stopped vec%0d", v), 64'(thr_stopped), 64'(VECS[v].exp_stopped));
            chk($sformatf("R11 flag vec%0d", v), 64'(unimpl_flag), 64'h0);
        end

        // R10 and R9: pulses of one write, one cycle wide
        access(1'b1, A_DIRECT, 64'h0000_0900_0000_0000);
        chk("R10 stop pulse thread2", 64'(got_stop), 64'h4);
        chk("R9 sreset pulse thread2", 64'(got_sreset), 64'h4);
        chk("R10 no start pulse", 64'(got_start), 64'h0);
        @(negedge clk);
        chk("R10 pulses gone next cycle", 64'({stop_pls, sreset_pls}), 64'h0);
        chk("R9 sreset keeps stopped", 64'(thr_stopped), 64'h4);
        access(1'b1, A_DIRECT, 64'h0000_1000_0000_0000);
        chk("R8 clear-maint pulse", 64'(got_clrmnt), 64'h4);
        chk("R8 clear-maint resumes", 64'(thr_stopped), 64'h0);

        // R2: request held across two edges gives one response
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = A_INFO;
        @(negedge clk);
        chk("R2 first ready", 64'(rsp_ready), 64'h1);
        @(negedge clk);
        req_valid = 1'b0;
        chk("R2 ack ignores held request", 64'(rsp_ready), 64'h0);
        @(negedge clk);
        chk("R2 idle after", 64'(rsp_ready), 64'h0);

        // R11: stray bit with a valid stop
        access(1'b1, A_DIRECT, 64'h8100_0000_0000_0000);
        chk("R11 flag on stray bit", 64'(unimpl_flag), 64'h1);
        chk("R11 valid stop still acts", 64'(thr_stopped), 64'h1);
        access(1'b0, A_STATE, 64'h0);
        chk("R11 flag sticky", 64'(unimpl_flag), 64'h1);

        // R13: reset clears flag and state
        do_reset();
        chk("R13 flag cleared", 64'(unimpl_flag), 64'h0);
        chk("R13 stopped cleared", 64'(thr_stopped), 64'h0);

        // R11: lane of a non-existent thread
        access(1'b1, A_DIRECT, 64'h0000_0000_0000_0001);
        chk("R11 low lane flagged", 64'(unimpl_flag), 64'h1);
        do_reset();

        // R12: unknown index read
        thr_halted = 4'hF;
        access(1'b0, 16'h0420 << 3, 64'h0);
        chk("R12 unknown read data", got_rdata, 64'h0);
        chk("R12 unknown read flag", 64'(unimpl_flag), 64'h1);
        do_reset();

        // R12: write to read-only state register with a stop pattern
        access(1'b1, A_STATE, 64'h0100_0000_0000_0000);
        chk("R12 ro write flag", 64'(unimpl_flag), 64'h1);
        chk("R12 ro write no stop", 64'({thr_stopped, got_stop}), 64'h0);
        do_reset();

        // R12: read of direct control, and R1 misaligned address
        access(1'b0, A_DIRECT, 64'h0);
        chk("R12 direct read flag", 64'(unimpl_flag), 64'h1);
        do_reset();
        access(1'b1, A_DIRECT | 16'h4, 64'h0100_0000_0000_0000);
        chk("R1 misaligned flag", 64'(unimpl_flag), 64'h1);
        chk("R1 misaligned no effect", 64'(thr_stopped), 64'h0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule